// File: doc/BRIEF.md
# Register Sequence Command Executor

This block takes one fixed-size command at a time and carries it out as a series of accesses on a simple 32-bit register bus. A command is sixteen 32-bit words on one wide input, accepted with a valid/ready handshake. Word 0 is a header that gives the operation and the payload length in bytes. Words 1 to 15 hold the payload.

Four operations are supported:
- a list of independent read-modify-writes;
- a chain of field updates applied to one register after at most one read;
- a burst of writes to one address;
- a polled wait that reads a register until a masked field matches, or until a timeout in microseconds runs out.

Each command ends with a one-cycle completion pulse that carries a status code. The command input stays not-ready while a command runs.

Top module: `regseq_exec`

## Requirements
- R1: Header word 0 is decoded as type = bits 7:0 and payload length = bits 29:24. Bits 15:8, 23:16 and 31:30 have no effect on execution.
- R2: For type 1, entry i occupies words 1+3i (address), 2+3i (mask) and 3+3i (value). Each entry reads the address, then writes (old AND NOT mask) OR (value AND mask). Entries run in order.
- R3: For a type 1 entry whose mask is all ones, there is no read, and the value is written directly.
- R4: For type 2, word 1 is the address and pair j is mask word 2+2j and value word 3+2j. The register is read once, before the first pair. Each pair is then merged into the held value, and the result is written with no read between writes.
- R5: For type 2, when the first mask is all ones the command performs no read at all.
- R6: For type 3, word 1 is the address. Data words 2 onward are written to that address in order, with no reads.
- R7: For type 4, word 1 is the address, word 2 the mask and word 3 the expected value. The block reads repeatedly until (data AND mask) equals the expected value, then completes with status 0.
- R8: For type 4, word 4 is a timeout in microseconds, where one microsecond is CYC_PER_US clock cycles. If the timeout has elapsed and a read still mismatches, the command completes with status 1.
- R9: Any type other than 1 to 4 makes no bus access and completes with status 2.
- R10: Completion is a single-cycle done pulse with a valid status (0 ok, 1 timeout, 2 unknown type). cmd_ready is low from acceptance until done.
- R11: Each access holds its strobe, address and write data until bus_ack. Read data is taken in the acknowledge cycle. Read and write strobes are never both high.
- R12: Entry counts are as follows, and a length that does not divide evenly is truncated to whole entries:
  - type 1: min(len/12, 5);
  - type 2: min((len-4)/8, 7);
  - type 3: min((len-4)/4, 14);
  - types 2 and 3: zero when len < 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to accept a command |
| cmd_data | input | 512 | Command words, word i at bits 32i+31:32i |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | 32 | Access address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access acknowledge |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Completion status, valid with done |

## Verification
The assertions check on every cycle the bus handshake rules: strobe exclusivity, and address and data held steady until the acknowledge. They also check the ready/done relationship and that done is a one-cycle pulse with a legal status. Only the bench scenarios can show the operation-level results:
- the merged values and the order of writes;
- which reads are skipped for all-ones masks;
- how entry counts follow the payload length;
- when a poll ends in a match rather than a timeout.

// File: rtl/regseq_exec.sv
module regseq_exec #(
  parameter int CYC_PER_US = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [511:0] cmd_data,
  output logic         bus_rd,
  output logic         bus_wr,
  output logic [31:0]  bus_addr,
  output logic [31:0]  bus_wdata,
  input  logic [31:0]  bus_rdata,
  input  logic         bus_ack,
  output logic         done,
  output logic [1:0]   status
);
  localparam int NW  = 16;
  localparam int PSW = $clog2(CYC_PER_US + 1);

  typedef enum logic [1:0] {S_IDLE, S_NEXT, S_READ, S_WRITE} st_t;
  st_t st;

  logic [31:0]    cmd [NW];
  logic [31:0]    hold, tmo;
  logic [3:0]     idx, cnt;
  logic [PSW-1:0] pre;
  logic [3:0]     ai, mi, vi;
  logic [31:0]    mask_w, val_w;

  wire [7:0] ctype = cmd[0][7:0];
  wire [5:0] plen  = cmd[0][29:24];
  wire [5:0] n_rmw = plen / 6'd12;
  wire [5:0] n_fld = (plen < 6'd4) ? 6'd0 : (plen - 6'd4) / 6'd8;
  wire [5:0] n_bst = (plen < 6'd4) ? 6'd0 : (plen - 6'd4) / 6'd4;

  always_comb begin
    case (ctype)
      8'd1:    cnt = (n_rmw > 6'd5)  ? 4'd5  : n_rmw[3:0];
      8'd2:    cnt = (n_fld > 6'd7)  ? 4'd7  : n_fld[3:0];
      8'd3:    cnt = (n_bst > 6'd14) ? 4'd14 : n_bst[3:0];
      default: cnt = 4'd0;
    endcase
  end

  always_comb begin
    ai = 4'd1;
    mi = 4'd2;
    vi = 4'd3;
    case (ctype)
      8'd1: begin ai = 4'(1 + 3 * idx); mi = 4'(2 + 3 * idx); vi = 4'(3 + 3 * idx); end
      8'd2: begin mi = 4'(2 + 2 * idx); vi = 4'(3 + 2 * idx); end
      8'd3: vi = 4'(2 + idx);
      default: ;
    endcase
  end

  assign mask_w = cmd[mi];
  assign val_w  = cmd[vi];

  function automatic logic [31:0] merge(input logic [31:0] old, m, v);
    return (old & ~m) | (v & m);
  endfunction

  wire all1  = &mask_w;
  wire match = (bus_rdata & cmd[2]) == cmd[3];
  wire tick  = pre == PSW'(CYC_PER_US - 1);

  assign cmd_ready = st == S_IDLE;
  assign bus_rd    = st == S_READ;
  assign bus_wr    = st == S_WRITE;
  assign bus_addr  = cmd[ai];
  assign bus_wdata = hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      status <= 2'd0;
      idx    <= 4'd0;
      hold   <= 32'd0;
      tmo    <= 32'd0;
      pre    <= '0;
      for (int i = 0; i < NW; i++) cmd[i] <= 32'd0;
    end else begin
      done <= 1'b0;
      if (st != S_IDLE && ctype == 8'd4) begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick && tmo != 32'd0) tmo <= tmo - 32'd1;
      end
      case (st)
        S_IDLE: if (cmd_valid) begin
          for (int i = 0; i < NW; i++) cmd[i] <= cmd_data[32*i +: 32];
          idx <= 4'd0;
          pre <= '0;
          tmo <= cmd_data[4*32 +: 32];
          st  <= S_NEXT;
        end
        S_NEXT: begin
          if (ctype < 8'd1 || ctype > 8'd4) begin
            done <= 1'b1; status <= 2'd2; st <= S_IDLE;
          end else if (ctype == 8'd4) begin
            st <= S_READ;
          end else if (idx == cnt) begin
            done <= 1'b1; status <= 2'd0; st <= S_IDLE;
          end else if (ctype == 8'd3) begin
            hold <= val_w; st <= S_WRITE;
          end else if (ctype == 8'd1) begin
            if (all1) begin hold <= val_w; st <= S_WRITE; end
            else st <= S_READ;
          end else if (idx == 4'd0 && !all1) begin
            st <= S_READ;
          end else begin
            hold <= merge(hold, mask_w, val_w); st <= S_WRITE;
          end
        end
        S_READ: if (bus_ack) begin
          if (ctype == 8'd4) begin
            if (match) begin done <= 1'b1; status <= 2'd0; st <= S_IDLE; end
            else if (tmo == 32'd0) begin done <= 1'b1; status <= 2'd1; st <= S_IDLE; end
            else st <= S_NEXT;
          end else begin
            hold <= merge(bus_rdata, mask_w, val_w);
            st   <= S_WRITE;
          end
        end
        S_WRITE: if (bus_ack) begin
          idx <= idx + 4'd1;
          st  <= S_NEXT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module regseq_exec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [31:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_ack,
  input logic        done,
  input logic [1:0]  status
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr)); // R11
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_ack |=> bus_wr && $stable(bus_addr) && $stable(bus_wdata)); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_ack |=> bus_rd && $stable(bus_addr)); // R11
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> !cmd_ready); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status != 2'd3 && cmd_ready && !bus_rd && !bus_wr); // R10
endmodule

bind regseq_exec regseq_exec_chk u_chk (.*);

// File: tb/regseq_exec_test.sv
module regseq_exec_test;
  logic clk = 0, rst_n = 0, cmd_valid = 0, bus_ack = 0;
  logic [511:0] cmd_data = '0;
  logic [31:0] bus_rdata = '0, bus_addr, bus_wdata;
  logic cmd_ready, bus_rd, bus_wr, done;
  logic [1:0] status;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  regseq_exec #(.CYC_PER_US(10)) uut (.*);

  logic [31:0] mem [16];
  logic [31:0] rcnt = 0;
  logic        lk [64];
  logic [31:0] la [64], ld [64];
  int lcnt = 0, wc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin bus_ack <= 0; wc <= 0; end
    else if (bus_ack) begin bus_ack <= 0; wc <= 0; end
    else if (bus_rd || bus_wr) begin
      if (wc == 1) begin
        bus_ack <= 1;
        if (lcnt < 64) begin
          lk[lcnt] <= bus_wr; la[lcnt] <= bus_addr;
          ld[lcnt] <= bus_wr ? bus_wdata : (bus_addr == 7 ? rcnt : mem[bus_addr[3:0]]);
          lcnt <= lcnt + 1;
        end
        if (bus_wr) mem[bus_addr[3:0]] <= bus_wdata;
        else begin
          bus_rdata <= (bus_addr == 7) ? rcnt : mem[bus_addr[3:0]];
          if (bus_addr == 7) rcnt <= rcnt + 1;
        end
      end else wc <= wc + 1;
    end
  end

  logic [31:0] w [16];
  logic [1:0] st;
  int cyc, base;

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clrw(input logic [7:0] typ, input logic [5:0] len, input logic [7:0] sub);
    for (int i = 0; i < 16; i++) w[i] = 0;
    w[0] = {2'b00, len, 8'h00, sub, typ};
  endtask

  task automatic send();
    @(negedge clk);
    for (int i = 0; i < 16; i++) cmd_data[32*i +: 32] = w[i];
    base = lcnt;
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    if (cyc >= 5000) chk("R10 done timeout", 0, 1);
    st = status;
  endtask

  task automatic logchk(input string req, input int k, input logic iswr, input logic [31:0] a, d);
    chk({req, " kind"}, 32'(lk[base+k]), 32'(iswr));
    chk({req, " addr"}, la[base+k], a);
    chk({req, " data"}, ld[base+k], d);
  endtask

  task automatic t_reset();
    chk("R10 reset ready", 32'(cmd_ready), 1);
    chk("R10 reset done", 32'(done), 0);
    chk("R11 reset strobes", 32'(bus_rd | bus_wr), 0);
  endtask

  task automatic t_rmw();
    mem[2] = 32'hAAAA5555;
    clrw(1, 24, 8'hFF);
    w[0][31:30] = 2'b11; w[0][23:16] = 8'h5A;   // R1 ignored fields
    w[1] = 2; w[2] = 32'h0000FFFF; w[3] = 32'h12341234;
    w[4] = 3; w[5] = 32'hFFFFFFFF; w[6] = 32'hDEADBEEF;
    send();
    chk("R2 status", 32'(st), 0);
    chk("R2 R3 access count", lcnt - base, 3);
    logchk("R2 read", 0, 0, 2, 32'hAAAA5555);
    logchk("R2 write", 1, 1, 2, 32'hAAAA1234);
    logchk("R3 direct write", 2, 1, 3, 32'hDEADBEEF);
    chk("R1 subtype ignored", mem[2], 32'hAAAA1234);
  endtask

  task automatic t_trunc();
    mem[5] = 0; mem[6] = 0;
    clrw(1, 23, 0);
    w[1] = 5; w[2] = 32'hFFFFFFFF; w[3] = 32'h11;
    w[4] = 6; w[5] = 32'hFFFFFFFF; w[6] = 32'h22;
    send();
    chk("R12 truncated count", lcnt - base, 1);
    chk("R12 second entry untouched", mem[6], 0);
  endtask

  task automatic t_field();
    mem[4] = 32'hF0F0F0F0;
    clrw(2, 28, 0);
    w[1] = 4;
    w[2] = 32'h000000FF; w[3] = 32'h00000011;
    w[4] = 32'h0000FF00; w[5] = 32'h00002200;
    w[6] = 32'h00000001; w[7] = 32'h00000000;
    send();
    chk("R4 access count", lcnt - base, 4);
    logchk("R4 single read", 0, 0, 4, 32'hF0F0F0F0);
    logchk("R4 write1", 1, 1, 4, 32'hF0F0F011);
    logchk("R4 write2", 2, 1, 4, 32'hF0F02211);
    logchk("R4 write3", 3, 1, 4, 32'hF0F02210);
  endtask

  task automatic t_field_skip();
    mem[8] = 32'h12345678;
    clrw(2, 20, 0);
    w[1] = 8; w[2] = 32'hFFFFFFFF; w[3] = 32'h5; w[4] = 32'h4; w[5] = 0;
    send();
    chk("R5 no read count", lcnt - base, 2);
    logchk("R5 write1", 0, 1, 8, 32'h5);
    logchk("R5 write2", 1, 1, 8, 32'h1);
  endtask

  task automatic t_burst();
    clrw(3, 63, 0);
    w[1] = 6;
    for (int i = 0; i < 14; i++) w[2+i] = 32'h100 + 32'(i) * 32'h11;
    send();
    chk("R12 R6 burst count", lcnt - base, 14);
    for (int i = 0; i < 14; i++) logchk("R6 burst write", i, 1, 6, 32'h100 + 32'(i) * 32'h11);
  endtask

  task automatic t_wait_ok();
    logic [31:0] r0;
    @(negedge clk);
    r0 = rcnt;
    clrw(4, 16, 0);
    w[1] = 7; w[2] = 32'hFF; w[3] = (r0 + 3) & 32'hFF; w[4] = 100;
    send();
    chk("R7 status", 32'(st), 0);
    chk("R7 poll count", lcnt - base, 4);
  endtask

  task automatic t_wait_tmo();
    mem[9] = 0;
    clrw(4, 16, 0);
    w[1] = 9; w[2] = 1; w[3] = 1; w[4] = 2;
    send();
    chk("R8 status", 32'(st), 1);
    chk("R8 min duration", 32'(cyc >= 20), 1);
    chk("R8 max duration", 32'(cyc <= 40), 1);
  endtask

  task automatic t_unknown();
    clrw(9, 60, 0);
    w[1] = 2; w[2] = 32'hFFFFFFFF; w[3] = 0;
    send();
    chk("R9 status", 32'(st), 2);
    chk("R9 no access", lcnt - base, 0);
    @(negedge clk);
    chk("R10 pulse one cycle", 32'(done), 0);
    chk("R10 ready after done", 32'(cmd_ready), 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rmw();
    t_trunc();
    t_field();
    t_field_skip();
    t_burst();
    t_wait_ok();
    t_wait_tmo();
    t_unknown();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule